// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single 16-bit timer channel for periodic event generation. Software programs it through a small byte-addressed register window: a control byte chooses the prescaler ratio, the count edge of the prescaled clock and whether the counter is cleared by a compare-A match. A mode byte must hold normal counting. A compare register holds the match value. The counter advances only while this channel's bit in a start vector is 1. That vector is held outside the block and is shared with neighbouring channels.

When the counter equals the compare value on a prescaled tick, the channel sets its compare-A flag. It can also restart the counter from zero on the following tick, which gives a period of compare + 1 ticks. The channel drives its output pin as the I/O control code selects, and it raises a level interrupt while the flag is set and its enable bit is 1. An interrupt handler clears the flag by reading the status byte and then writing a 0 to bit 0.

Top module: `cmt_channel`

## Requirements
- R1: The prescaler and the counter advance only while `start_vec_i[CH_IDX]` (default bit 1) is 1. While that bit is 0 the counter holds its value and the prescaler phase returns to 0. Bits for other channels have no effect.
- R2: Control bits [2:0] select the tick rate: 0 gives one tick per clock, 1 one per 4 clocks, 2 one per 16 and 3 one per 64. Codes 4 to 7 produce no ticks. The prescaler phase starts at 0 in the first running cycle.
- R3: Control bits [4:3] select the tick edge. With phase p counted modulo the ratio N: 0 (and 3) ticks when p = N-1, 1 ticks when p = (N-1)/2 with integer division, and 2 ticks at both points. At ratio 1, every mode gives exactly one tick per clock.
- R4: With control bits [7:5] = 1, a tick on which the counter equals the compare value loads 0, so the period is compare + 1 ticks. With any other clear code the counter wraps from 0xFFFF to 0.
- R5: A tick on which the counter equals the compare value sets status bit 0 (the compare-A flag), whatever the clear code.
- R6: The flag is cleared only by a status write with bit 0 = 0 that follows a status read made while the flag was 1. Any status write ends that armed state. A write with bit 0 = 1, or a 0-write that no read preceded, leaves the flag set.
- R7: If a clearing write and a new match happen in the same cycle, the flag stays set.
- R8: `irq_o` is a level equal to the flag AND interrupt-enable bit 0.
- R9: The low nibble of the I/O control byte sets the pin level when written: codes 1 to 3 give 0, codes 5 to 7 give 1, and other codes leave the pin unchanged. On a match, low bits 1, 2 and 3 clear, set or toggle the pin when nibble bit 3 is 0. Code 0 and code 4 hold the pin.
- R10: Byte offsets are control 0, mode 1, I/O control 2, interrupt enable 4, status 5 (flag in bit 0), counter 6 (16-bit) and compare 8 (16-bit). Read data is combinational, other offsets read 0, and all registers reset to 0. A counter write takes priority over counting.
- R11: The counter and the prescaler run only when mode bits [3:0] are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_vec_i | input | 8 | Shared start vector, one bit per channel |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms the flag clear) |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data (8-bit registers use bits [7:0]) |
| rdata_o | output | 16 | Read data for addr_i |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Compare-A interrupt request, level |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a new match, because the free-running match time is not visible at the ports. The bench stops the channel first and arms the clear with a status read. It then loads the counter with the compare value and, in a single cycle, sets the start bit and writes 0 to the status register. At ratio 1 the first running cycle is then certain to be the match cycle. A behavioural model runs every cycle and is compared against the read data, the pin and the interrupt for each prescaler ratio, edge mode and pin code.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  parameter int unsigned OFS_CTRL = 0;
  parameter int unsigned OFS_MODE = 1;
  parameter int unsigned OFS_IOC  = 2;
  parameter int unsigned OFS_IEN  = 4;
  parameter int unsigned OFS_STAT = 5;
  parameter int unsigned OFS_CNT  = 6;
  parameter int unsigned OFS_CMP  = 8;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_RSVD = 2'd3
  } edge_sel_e;

  parameter logic [2:0] CLR_NONE = 3'd0;
  parameter logic [2:0] CLR_CMPA = 3'd1;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [2:0]      psc_i,
  input  cmt_pkg::edge_sel_e edge_i,
  output logic            tick_o
);
  import cmt_pkg::*;

  logic [PRE_W-1:0] pre_q, mask, low;
  logic valid, rise, fall, hit;

  always_comb begin
    valid = 1'b1;
    case (psc_i)
      3'd0: mask = PRE_W'(0);
      3'd1: mask = PRE_W'(3);
      3'd2: mask = PRE_W'(15);
      3'd3: mask = PRE_W'(63);
      default: begin
        mask  = '0;
        valid = 1'b0;
      end
    endcase
  end

  assign low  = pre_q & mask;
  assign rise = (low == mask);
  assign fall = (low == (mask >> 1));

  always_comb begin
    case (edge_i)
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = rise;
    endcase
  end

  assign tick_o = run_i & valid & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + PRE_W'(1);
    else             pre_q <= '0;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;

  assign match_o = tick_i & (cnt_q == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i) begin
      if (clr_en_i && match_o)      cnt_q <= '0;
      else                          cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [3:0] code_i,
  input  logic [3:0] cur_code_i,
  input  logic       match_i,
  output logic       pin_o
);
  logic pin_q;

  assign pin_o = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (cfg_wr_i) begin
      // initial level taken from the new code
      if (!code_i[3] && code_i[1:0] != 2'd0) pin_q <= code_i[2];
    end else if (match_i && !cur_code_i[3]) begin
      case (cur_code_i[1:0])
        2'd1:    pin_q <= 1'b0;
        2'd2:    pin_q <= 1'b1;
        2'd3:    pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase
    end
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int CH_IDX  = 1,
  parameter int START_W = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int PRE_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [START_W-1:0] start_vec_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pin_o,
  output logic              irq_o
);
  import cmt_pkg::*;

  localparam int BYTE_W = 8;

  logic [BYTE_W-1:0] ctrl_q, mode_q, ioc_q, ien_q;
  logic [CNT_W-1:0]  cmp_q, cnt_q;
  logic flag_q, armed_q;
  logic run, tick, match;
  logic wr_ctrl, wr_mode, wr_ioc, wr_ien, wr_stat, wr_cnt, wr_cmp, rd_stat;

  assign wr_ctrl = wr_en_i && addr_i == ADDR_W'(OFS_CTRL);
  assign wr_mode = wr_en_i && addr_i == ADDR_W'(OFS_MODE);
  assign wr_ioc  = wr_en_i && addr_i == ADDR_W'(OFS_IOC);
  assign wr_ien  = wr_en_i && addr_i == ADDR_W'(OFS_IEN);
  assign wr_stat = wr_en_i && addr_i == ADDR_W'(OFS_STAT);
  assign wr_cnt  = wr_en_i && addr_i == ADDR_W'(OFS_CNT);
  assign wr_cmp  = wr_en_i && addr_i == ADDR_W'(OFS_CMP);
  assign rd_stat = rd_en_i && addr_i == ADDR_W'(OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[BYTE_W-1:0];
      if (wr_mode) mode_q <= wdata_i[BYTE_W-1:0];
      if (wr_ioc)  ioc_q  <= wdata_i[BYTE_W-1:0];
      if (wr_ien)  ien_q  <= wdata_i[BYTE_W-1:0];
      if (wr_cmp)  cmp_q  <= wdata_i[CNT_W-1:0];
    end
  end

  assign run = start_vec_i[CH_IDX] && (mode_q[3:0] == 4'd0);

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .psc_i  (ctrl_q[2:0]),
    .edge_i (edge_sel_e'(ctrl_q[4:3])),
    .tick_o (tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .clr_en_i   (ctrl_q[7:5] == CLR_CMPA),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .cmp_i      (cmp_q),
    .cnt_o      (cnt_q),
    .match_o    (match)
  );

  cmt_pin u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wr_i   (wr_ioc),
    .code_i     (wdata_i[3:0]),
    .cur_code_i (ioc_q[3:0]),
    .match_i    (match),
    .pin_o      (pin_o)
  );

  // flag: set wins over an armed zero-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (match)                                   flag_q <= 1'b1;
      else if (wr_stat && !wdata_i[0] && armed_q)  flag_q <= 1'b0;
      if (wr_stat)                                 armed_q <= 1'b0;
      else if (rd_stat && flag_q)                  armed_q <= 1'b1;
    end
  end

  assign irq_o = flag_q & ien_q[0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CTRL): rdata_o[BYTE_W-1:0] = ctrl_q;
      ADDR_W'(OFS_MODE): rdata_o[BYTE_W-1:0] = mode_q;
      ADDR_W'(OFS_IOC):  rdata_o[BYTE_W-1:0] = ioc_q;
      ADDR_W'(OFS_IEN):  rdata_o[BYTE_W-1:0] = ien_q;
      ADDR_W'(OFS_STAT): rdata_o[0]          = flag_q;
      ADDR_W'(OFS_CNT):  rdata_o[CNT_W-1:0]  = cnt_q;
      ADDR_W'(OFS_CMP):  rdata_o[CNT_W-1:0]  = cmp_q;
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int CH_IDX  = 1,
  parameter int START_W = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [START_W-1:0] start_vec_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic               match_i,
  input logic               flag_i,
  input logic [7:0]         ctrl_i,
  input logic [7:0]         ioc_i,
  input logic               pin_o,
  input logic               irq_o
);
  logic cnt_wr, stat_wr, ioc_wr;
  assign cnt_wr  = wr_en_i && addr_i == ADDR_W'(6);
  assign stat_wr = wr_en_i && addr_i == ADDR_W'(5);
  assign ioc_wr  = wr_en_i && addr_i == ADDR_W'(2);

  assert_stopped_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_vec_i[CH_IDX] && !cnt_wr) |=> $stable(cnt_i));

  assert_clear_on_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && ctrl_i[7:5] == 3'd1 && !cnt_wr) |=> (cnt_i == '0));

  assert_flag_from_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(match_i));

  assert_write_one_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[0] && flag_i) |=> flag_i);

  assert_match_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_i);

  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_i);

  assert_toggle_on_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !ioc_wr && ioc_i[3:0] == 4'd3) |=> (pin_o != $past(pin_o)));
endmodule

bind cmt_channel cmt_channel_chk #(
  .CH_IDX(CH_IDX), .START_W(START_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_vec_i (start_vec_i),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .cnt_i       (cnt_q),
  .match_i     (match),
  .flag_i      (flag_q),
  .ctrl_i      (ctrl_q),
  .ioc_i       (ioc_q),
  .pin_o       (pin_o),
  .irq_o       (irq_o)
);

// File: tb/cmt_channel_tb.sv
`timescale 1ns/1ps
module cmt_channel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  start_vec_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        pin_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cmt_channel u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_vec_i(start_vec_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_o(pin_o), .irq_o(irq_o)
  );

  // behavioural model
  logic [7:0]  m_ctrl, m_mode, m_ioc, m_ien;
  logic [15:0] m_cnt, m_cmp;
  logic        m_flag, m_armed, m_pin;
  int          m_pre;

  function automatic logic [15:0] exp_rdata(input logic [3:0] a);
    case (a)
      4'd0: return {8'h00, m_ctrl};
      4'd1: return {8'h00, m_mode};
      4'd2: return {8'h00, m_ioc};
      4'd4: return {8'h00, m_ien};
      4'd5: return {15'h0, m_flag};
      4'd6: return m_cnt;
      4'd8: return m_cmp;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_mode = 0; m_ioc = 0; m_ien = 0; m_cnt = 0; m_cmp = 0;
      m_flag = 0; m_armed = 0; m_pin = 0; m_pre = 0;
    end else begin
      int n;
      bit run, tick, match, rise, fall, w;
      logic [1:0] edg;
      run = start_vec_i[1] && (m_mode[3:0] == 0);
      case (m_ctrl[2:0])
        3'd0: n = 1;
        3'd1: n = 4;
        3'd2: n = 16;
        3'd3: n = 64;
        default: n = 0;
      endcase
      edg = m_ctrl[4:3];
      tick = 0;
      if (run && n != 0) begin
        rise = (m_pre % n) == n - 1;
        fall = (m_pre % n) == (n - 1) / 2;
        tick = (edg == 2'd1) ? fall : (edg == 2'd2) ? (rise || fall) : rise;
      end
      match = tick && (m_cnt == m_cmp);
      w = wr_en_i;
      // pin
      if (w && addr_i == 2) begin
        if (wdata_i[3:0] inside {4'd1, 4'd2, 4'd3}) m_pin = 0;
        else if (wdata_i[3:0] inside {4'd5, 4'd6, 4'd7}) m_pin = 1;
      end else if (match) begin
        case (m_ioc[3:0])
          4'd1, 4'd5: m_pin = 0;
          4'd2, 4'd6: m_pin = 1;
          4'd3, 4'd7: m_pin = !m_pin;
          default: ;
        endcase
      end
      // flag and arm
      if (match) m_flag = 1;
      else if (w && addr_i == 5 && !wdata_i[0] && m_armed) m_flag = 0;
      if (w && addr_i == 5) m_armed = 0;
      else if (rd_en_i && addr_i == 5 && exp_rdata(4'd5) == 16'h1) m_armed = 1;
      // counter
      if (w && addr_i == 6) m_cnt = wdata_i;
      else if (tick) m_cnt = (m_ctrl[7:5] == 3'd1 && match) ? 16'h0 : m_cnt + 16'h1;
      m_pre = run ? (m_pre + 1) % 64 : 0;
      if (w && addr_i == 0) m_ctrl = wdata_i[7:0];
      if (w && addr_i == 1) m_mode = wdata_i[7:0];
      if (w && addr_i == 2) m_ioc  = wdata_i[7:0];
      if (w && addr_i == 4) m_ien  = wdata_i[7:0];
      if (w && addr_i == 8) m_cmp  = wdata_i;
    end
    #2;
    if (rst_ni && !done) begin
      check("R10 rdata", rdata_o, exp_rdata(addr_i));
      check("R9 pin", pin_o, m_pin);
      check("R8 irq", irq_o, m_flag & m_ien[0]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en_i = 1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic peek(input logic [3:0] a, input string tag);
    addr_i = a;
    #1;
    check(tag, rdata_o, exp_rdata(a));
  endtask

  task automatic run_for(input int n);
    start_vec_i = 8'h02;
    idle(n);
    start_vec_i = 8'h00;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state, R10
    for (int a = 0; a < 10; a++) peek(4'(a), "R10 reset");
    check("R9 reset pin", pin_o, 0);
    check("R8 reset irq", irq_o, 0);

    // periodic clear on compare A, div 1, toggle pin, R4 R5 R9
    @(negedge clk_i);
    wr(4'd0, 16'h0020);
    wr(4'd8, 16'd5);
    wr(4'd4, 16'h0001);
    wr(4'd2, 16'h0003);
    run_for(20);
    peek(4'd6, "R4 periodic count");
    peek(4'd5, "R5 flag set");
    check("R8 irq level", irq_o, 1);

    // R6: zero write without read keeps flag, write one keeps flag
    wr(4'd5, 16'h0000);
    peek(4'd5, "R6 no read");
    check("R6 no read flag", rdata_o, 1);
    @(negedge clk_i);
    rd(4'd5);
    wr(4'd5, 16'h0001);
    peek(4'd5, "R6 write one");
    check("R6 write one flag", rdata_o, 1);
    @(negedge clk_i);
    rd(4'd5);
    wr(4'd5, 16'h00FE);
    peek(4'd5, "R6 cleared");
    check("R6 cleared flag", rdata_o, 0);
    check("R8 irq low", irq_o, 0);

    // R7: clear and match in same cycle
    @(negedge clk_i);
    wr(4'd6, 16'd5);
    run_for(1);
    peek(4'd5, "R5 one-tick match");
    @(negedge clk_i);
    rd(4'd5);
    wr(4'd6, 16'd5);
    start_vec_i = 8'h02;
    wr(4'd5, 16'h0000);
    start_vec_i = 8'h00;
    peek(4'd5, "R7 same cycle");
    check("R7 flag kept", rdata_o, 1);

    // R1: other channels' bits do nothing
    @(negedge clk_i);
    wr(4'd6, 16'd1);
    start_vec_i = 8'hFD;
    idle(8);
    start_vec_i = 8'h00;
    peek(4'd6, "R1 gated");
    check("R1 held", rdata_o, 1);

    // R11: non-normal mode holds
    @(negedge clk_i);
    wr(4'd1, 16'h0002);
    run_for(8);
    peek(4'd6, "R11 mode hold");
    check("R11 held", rdata_o, 1);
    @(negedge clk_i);
    wr(4'd1, 16'h0000);

    // R2/R3: prescaler ratios and edges, free running
    wr(4'd8, 16'hFFF0);
    wr(4'd0, 16'h0001);  // div 4 rising
    wr(4'd6, 16'h0000);
    run_for(23);
    peek(4'd6, "R2 div4");
    check("R2 div4 count", rdata_o, 5);
    @(negedge clk_i);
    wr(4'd0, 16'h000A);  // div 16 falling
    wr(4'd6, 16'h0000);
    run_for(40);
    peek(4'd6, "R3 div16 falling");
    check("R3 div16 falling count", rdata_o, 3);
    @(negedge clk_i);
    wr(4'd0, 16'h0013);  // div 64 both
    wr(4'd6, 16'h0000);
    run_for(130);
    peek(4'd6, "R3 div64 both");
    check("R3 div64 both count", rdata_o, 4);
    @(negedge clk_i);
    wr(4'd0, 16'h0005);  // unsupported ratio
    wr(4'd6, 16'h0000);
    run_for(20);
    peek(4'd6, "R2 unsupported");
    check("R2 unsupported count", rdata_o, 0);

    // R4: wrap without clear; R9 set/clear codes
    @(negedge clk_i);
    wr(4'd0, 16'h0000);
    wr(4'd8, 16'h0001);
    wr(4'd2, 16'h0005);  // start 1, clear on match
    check("R9 init high", pin_o, 1);
    wr(4'd6, 16'hFFFE);
    run_for(6);
    peek(4'd6, "R4 wrap");
    check("R4 wrap count", rdata_o, 4);
    check("R9 clear on match", pin_o, 0);
    @(negedge clk_i);
    wr(4'd2, 16'h0002);  // start 0, set on match
    wr(4'd6, 16'h0000);
    run_for(3);
    check("R9 set on match", pin_o, 1);
    @(negedge clk_i);
    wr(4'd2, 16'h0000);  // hold
    wr(4'd4, 16'h0000);
    wr(4'd6, 16'h0000);
    run_for(5);
    check("R9 hold", pin_o, 1);
    check("R8 disabled irq", irq_o, 0);

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule